// File: doc/BRIEF.md
# Address-Range Cache Maintenance Engine

This block carries out one cache maintenance operation across a span of physical memory. Software writes a first address and a stop address into two 64-bit registers. It then writes a control word that selects the kind of maintenance and sets a go bit. From then on the engine steps through the span one 64-byte line at a time. For each line it offers a request on a valid/ready port toward the cache controller. The request carries the line address and the operation kind.

The go bit reads back as 1 for as long as the walk runs. Hardware clears it in the same clock edge that accepts the final line, so software only polls one bit to learn that the work is done. The address registers and the operation field are frozen while the walk is in progress. A request with the reserved operation code, or with an empty span, finishes at once and sends no request to the cache.

Top module: `cme_engine`

## Requirements
- R1: After reset every register reads as zero and `mnt_valid` is low.
- R2: The first-address register sits at offset 0x00 and the stop-address register at 0x08. Each keeps bits 39:0 of the written word, and bits 63:40 read back as zero.
- R3: The control register at offset 0x10 reads back with bit 0 as busy/go, bits 2:1 as the operation code and bit 3 as a sticky error. All other bits read as zero. A control write with bit 0 clear stores only the operation code.
- R4: A walk issues exactly the lines from the first address rounded down to a multiple of 64 up to, but not including, the stop address. Lines go out in ascending order in steps of 64, which gives ceil((stop - aligned_first)/64) requests.
- R5: Each request carries the operation code of the start write: 0 for clean plus invalidate, 1 for invalidate without writeback, 2 for clean that leaves the line valid.
- R6: While `mnt_valid` is high and `mnt_ready` is low, the next cycle still has `mnt_valid` high, with `mnt_addr` and `mnt_mode` unchanged.
- R7: The busy bit reads 1 from the cycle after the start write. It drops in the edge that completes the handshake for the final line.
- R8: If the stop address is not greater than the first address, a start issues no request and busy never rises.
- R9: While busy, writes to either address register and to the control register have no effect.
- R10: A start with operation code 3 issues no request, leaves busy low and sets the error bit. The next start with a code from 0 to 2 clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset for both write and read |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr`, combinational |
| mnt_valid | output | 1 | Maintenance request valid |
| mnt_ready | input | 1 | Maintenance request accepted |
| mnt_addr | output | 40 | Line address of the request |
| mnt_mode | output | 2 | Operation code of the request |

## Verification
The bench targets unaligned first addresses and stop addresses that sit a single byte past a line boundary. A design that forgets the round-down, or that treats the stop address as inclusive, sends one line too many or too few. Empty and inverted spans, and the reserved code, are run to confirm that no request leaks out and that busy never flashes high. Register writes are aimed at a walk stalled by a held-low ready to show that its parameters cannot shift mid-flight. The stalled port itself is watched: a design that advanced without a handshake would show a moving address.

// File: rtl/cme_pkg.sv
package cme_pkg;
   localparam int REG_AW = 5;

   typedef enum logic [1:0] {
      OP_CLEAN_INV  = 2'd0,
      OP_INV_ONLY   = 2'd1,
      OP_CLEAN_KEEP = 2'd2,
      OP_RESERVED   = 2'd3
   } cme_op_e;

   localparam logic [REG_AW-1:0] OFF_FIRST = 5'h00;
   localparam logic [REG_AW-1:0] OFF_STOP  = 5'h08;
   localparam logic [REG_AW-1:0] OFF_CTRL  = 5'h10;

   localparam int CTRL_GO_BIT  = 0;
   localparam int CTRL_OP_LSB  = 1;
   localparam int CTRL_ERR_BIT = 3;
endpackage

// File: rtl/cme_regs.sv
module cme_regs
   import cme_pkg::*;
#(
   parameter int ADDR_W = 40,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              busy_i,
   output logic [ADDR_W-1:0] first_q,
   output logic [ADDR_W-1:0] stop_q,
   output cme_op_e           op_q,
   output logic              launch
);
   localparam int PAD_W = DATA_W - ADDR_W;

   logic    err_q;
   logic    wr_ok, ctrl_wr, go_req;
   cme_op_e req_op;

   assign wr_ok   = wr_en && !busy_i;
   assign ctrl_wr = wr_ok && (addr == OFF_CTRL);
   assign go_req  = ctrl_wr && wdata[CTRL_GO_BIT];
   assign req_op  = cme_op_e'(wdata[CTRL_OP_LSB +: 2]);
   assign launch  = go_req && (req_op != OP_RESERVED) && (first_q < stop_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_q <= '0;
         stop_q  <= '0;
         op_q    <= OP_CLEAN_INV;
         err_q   <= 1'b0;
      end else begin
         if (wr_ok && addr == OFF_FIRST) first_q <= wdata[ADDR_W-1:0];
         if (wr_ok && addr == OFF_STOP)  stop_q  <= wdata[ADDR_W-1:0];
         if (ctrl_wr)                    op_q    <= req_op;
         if (go_req)                     err_q   <= (req_op == OP_RESERVED);
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         OFF_FIRST: rdata = {{PAD_W{1'b0}}, first_q};
         OFF_STOP:  rdata = {{PAD_W{1'b0}}, stop_q};
         OFF_CTRL: begin
            rdata[CTRL_GO_BIT]       = busy_i;
            rdata[CTRL_OP_LSB +: 2]  = op_q;
            rdata[CTRL_ERR_BIT]      = err_q;
         end
         default: rdata = '0;
      endcase
   end

   // R9: parameters frozen while busy
   p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> ($stable(first_q) && $stable(stop_q) && $stable(op_q)));

   // R10: reserved code never starts a walk and flags error
   p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (go_req && req_op == OP_RESERVED) |=> (!busy_i && err_q));

   // R8: empty span leaves the engine idle
   p_empty_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (go_req && !(first_q < stop_q)) |=> !busy_i);
endmodule

// File: rtl/cme_walker.sv
module cme_walker
   import cme_pkg::*;
#(
   parameter int ADDR_W     = 40,
   parameter int LINE_BYTES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [ADDR_W-1:0] first_i,
   input  logic [ADDR_W-1:0] stop_i,
   input  cme_op_e           op_i,
   output logic              busy_o,
   output logic              m_valid,
   input  logic              m_ready,
   output logic [ADDR_W-1:0] m_addr,
   output logic [1:0]        m_mode
);
   localparam int OFF_W = $clog2(LINE_BYTES);

   generate
      if ((1 << OFF_W) != LINE_BYTES) begin : g_bad_line
         $error("LINE_BYTES must be a power of two");
      end
      if (OFF_W >= ADDR_W) begin : g_bad_width
         $error("LINE_BYTES too large for ADDR_W");
      end
   endgenerate

   logic              busy_q;
   logic [ADDR_W-1:0] line_q, line_start;
   logic [ADDR_W:0]   line_next;
   logic              last_line;

   generate
      if (OFF_W == 0) begin : g_no_align
         assign line_start = first_i;
      end else begin : g_align
         assign line_start = {first_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      end
   endgenerate

   assign line_next = {1'b0, line_q} + (ADDR_W+1)'(LINE_BYTES);
   assign last_line = line_next >= {1'b0, stop_i};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         line_q <= '0;
      end else if (launch && !busy_q) begin
         busy_q <= 1'b1;
         line_q <= line_start;
      end else if (busy_q && m_ready) begin
         if (last_line) busy_q <= 1'b0;
         else           line_q <= line_next[ADDR_W-1:0];
      end
   end

   assign busy_o  = busy_q;
   assign m_valid = busy_q;
   assign m_addr  = line_q;
   assign m_mode  = op_i;

   // R6: request held until accepted
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_mode)));

   // R4: every issued line lies below the stop address
   p_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> ({1'b0, m_addr} < {1'b0, stop_i}));

   // R4: line addresses step upward on each handshake
   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_ready && !last_line) |=> (m_valid && m_addr > $past(m_addr)));

   // R5: reserved code never reaches the port
   p_no_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> (m_mode != 2'd3));
endmodule

// File: rtl/cme_engine.sv
module cme_engine
   import cme_pkg::*;
#(
   parameter int ADDR_W     = 40,
   parameter int DATA_W     = 64,
   parameter int LINE_BYTES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [4:0]        reg_addr,
   input  logic [63:0]       reg_wdata,
   output logic [63:0]       reg_rdata,
   output logic              mnt_valid,
   input  logic              mnt_ready,
   output logic [39:0]       mnt_addr,
   output logic [1:0]        mnt_mode
);
   generate
      if (DATA_W != 64 || ADDR_W != 40 || ADDR_W > DATA_W) begin : g_bad_cfg
         $error("port widths are fixed at 64-bit data and 40-bit address");
      end
   endgenerate

   logic [ADDR_W-1:0] first_q, stop_q;
   cme_op_e           op_q;
   logic              launch, busy;

   cme_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .busy_i  (busy),
      .first_q (first_q),
      .stop_q  (stop_q),
      .op_q    (op_q),
      .launch  (launch)
   );

   cme_walker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_walker (
      .clk     (clk),
      .rst_n   (rst_n),
      .launch  (launch),
      .first_i (first_q),
      .stop_i  (stop_q),
      .op_i    (op_q),
      .busy_o  (busy),
      .m_valid (mnt_valid),
      .m_ready (mnt_ready),
      .m_addr  (mnt_addr),
      .m_mode  (mnt_mode)
   );

   // R7: busy drops only through a handshake
   p_busy_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mnt_valid) |-> $past(mnt_ready));
endmodule

// File: tb/cme_engine_tb.sv
`timescale 1ns/1ps
module cme_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        mnt_valid;
   logic        mnt_ready = 1'b0;
   logic [39:0] mnt_addr;
   logic [1:0]  mnt_mode;

   int          total = 0, bad = 0;
   bit          hold_rdy = 1'b0;
   logic [39:0] exp_line = '0;
   logic [1:0]  exp_mode = '0;
   int          seen = 0;
   bit          prev_stall = 1'b0;
   logic [39:0] prev_addr = '0;
   logic [1:0]  prev_mode = '0;

   always #2.5 clk = ~clk;

   cme_engine u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mnt_valid(mnt_valid),
      .mnt_ready(mnt_ready), .mnt_addr(mnt_addr), .mnt_mode(mnt_mode)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) mnt_ready <= hold_rdy ? 1'b0 : ($urandom % 4 != 0);

   always @(posedge clk) begin
      if (rst_n) begin
         if (prev_stall)  // R6
            chk(mnt_valid && mnt_addr == prev_addr && mnt_mode == prev_mode,
                "R6 hold", {22'd0, mnt_valid, mnt_mode, mnt_addr}, {22'd0, 1'b1, prev_mode, prev_addr});
         prev_stall = mnt_valid && !mnt_ready;
         prev_addr  = mnt_addr;
         prev_mode  = mnt_mode;
         if (mnt_valid && mnt_ready) begin
            seen++;
            chk(mnt_addr == exp_line, "R4 line address", {24'd0, mnt_addr}, {24'd0, exp_line});
            chk(mnt_mode == exp_mode, "R5 mode", {62'd0, mnt_mode}, {62'd0, exp_mode});
            exp_line = exp_line + 40'd64;
         end
      end
   end

   task automatic wr(input logic [4:0] a, input logic [63:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [63:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   function automatic int exp_count(input logic [39:0] s, input logic [39:0] e);
      logic [63:0] base;
      if (e <= s) return 0;
      base = {24'd0, s & ~40'h3F};
      return int'(({24'd0, e} - base + 64'd63) / 64);
   endfunction

   task automatic wait_idle();
      logic [63:0] v;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         rd(5'h10, v);
         if (!v[0]) break;
      end
   endtask

   task automatic run_op(input logic [39:0] s, input logic [39:0] e, input logic [1:0] m);
      logic [63:0] v;
      int n;
      n = (m == 2'd3) ? 0 : exp_count(s, e);
      exp_line = s & ~40'h3F;
      exp_mode = m;
      seen = 0;
      wr(5'h00, {24'hABCDEF, s});
      wr(5'h08, {24'h123456, e});
      wr(5'h10, {61'd0, m, 1'b1});
      rd(5'h10, v);
      if (n > 0) chk(v[0] == 1'b1, "R7 busy after start", v, 64'd1);
      else       chk(v[0] == 1'b0, "R8 no busy on empty/reserved", v, 64'd0);
      wait_idle();
      @(negedge clk);
      rd(5'h10, v);
      chk(v[0] == 1'b0, "R7 busy cleared", v, 64'd0);
      chk(seen == n, "R4 line count", 64'(seen), 64'(n));
      chk(v[3] == (m == 2'd3), "R10 error bit", {63'd0, v[3]}, {63'd0, (m == 2'd3)});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [63:0] v;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      rd(5'h00, v); chk(v == 0, "R1 first reset", v, 0);
      rd(5'h08, v); chk(v == 0, "R1 stop reset", v, 0);
      rd(5'h10, v); chk(v == 0, "R1 ctrl reset", v, 0);
      chk(!mnt_valid, "R1 valid reset", {63'd0, mnt_valid}, 0);
      // R2
      wr(5'h00, '1); rd(5'h00, v); chk(v == 64'hFF_FFFF_FFFF, "R2 first width", v, 64'hFF_FFFF_FFFF);
      wr(5'h08, 64'hFFFF_0000_0000_1234); rd(5'h08, v); chk(v == 64'h1234, "R2 stop width", v, 64'h1234);
      // R3
      wr(5'h10, 64'hFFFF_FFFF_FFFF_FFF4); rd(5'h10, v); chk(v == 64'h4, "R3 ctrl layout", v, 64'h4);
      rd(5'h18, v); chk(v == 0, "R3 unmapped offset", v, 0);
      // directed walks
      run_op(40'h1000, 40'h1100, 2'd0);
      run_op(40'h1010, 40'h1041, 2'd1);
      run_op(40'h2000, 40'h2001, 2'd2);
      run_op(40'h3000, 40'h3000, 2'd2); // R8
      run_op(40'h4000, 40'h3000, 2'd0); // R8
      run_op(40'h5000, 40'h5100, 2'd3); // R10
      run_op(40'h5000, 40'h5080, 2'd1); // R10 cleared
      // R9: writes during a stalled walk
      hold_rdy = 1'b1;
      exp_line = 40'h6000; exp_mode = 2'd2; seen = 0;
      wr(5'h00, 64'h6000); wr(5'h08, 64'h6100); wr(5'h10, 64'h5);
      wr(5'h00, 64'h9000); wr(5'h08, 64'h0); wr(5'h10, 64'h3);
      rd(5'h00, v); chk(v == 64'h6000, "R9 first frozen", v, 64'h6000);
      rd(5'h08, v); chk(v == 64'h6100, "R9 stop frozen", v, 64'h6100);
      rd(5'h10, v); chk(v == 64'h5, "R9 ctrl frozen", v, 64'h5);
      chk(mnt_valid && mnt_addr == 40'h6000, "R6 stalled request", {24'd0, mnt_addr}, 64'h6000);
      hold_rdy = 1'b0;
      wait_idle();
      @(negedge clk);
      chk(seen == 4, "R9 walk unchanged", 64'(seen), 64'd4);
      // random walks
      for (int k = 0; k < 40; k++) begin
         logic [39:0] s, e;
         s = {1'b0, 7'($urandom), 32'($urandom)};
         e = s + 40'($urandom % 1200) - 40'($urandom % 64);
         run_op(s, e, 2'($urandom % 4));
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule